// File: doc/BRIEF.md
# Multiplexed Bus Target With Wait Insertion

This block sits on the memory and peripheral side of a processor bus that carries the low address byte and the data byte on the same eight lines. At the start of each cycle an address strobe marks the moment when the shared lines hold the address. The block captures that byte, together with the upper address bits and a memory/I-O space flag. It then answers read, write and interrupt acknowledge strobes against a 256-byte memory array and a bank of sixteen I/O registers.

Slow targets can stretch a cycle. For this, the block holds its ready output low for a number of clocks, from 0 to 7, set separately for the memory space and the I/O space. During an interrupt acknowledge the address lines carry nothing. The block ignores them and returns a configured vector byte. The data driver is released whenever the block is not sourcing data. All inputs are sampled on the rising clock edge.

Top module: `bus_target`

## Requirements
- R1: After reset, ready is high, ad_oe is low, and every memory byte and I/O register reads as 0x00.
- R2: The low address byte on ad_i is captured on each clock edge where ale is high, and is held unchanged while ale stays low, whatever ad_i then carries.
- R3: With space_mem = 1 and addr_hi equal to MEM_PAGE (default 0x0A0), the latched low byte selects one of 256 memory bytes. With space_mem = 0, addr_hi equal to IO_PAGE (default 0x000) and the latched low byte's bits 7:4 equal to bits 7:4 of IO_BASE (default 0x30), bits 3:0 select one of 16 I/O registers.
- R4: While rd_n is low and inta_n is high, ad_oe is high and ad_o carries the selected byte.
- R5: A write stores the ad_i byte sampled on the last clock edge at which wr_n was low. The store happens on the first edge at which wr_n is sampled high again, and later reads return the stored byte.
- R6: A read or write whose address matches neither range changes no storage, reads as 0xFF, and leaves ready high.
- R7: For an in-range read or write, ready is low for exactly N clocks, starting after the edge that first samples the strobe. N is cfg_mem_waits in memory space and cfg_io_waits in I/O space. N = 0 leaves ready high.
- R8: While inta_n is low, ad_oe is high and ad_o equals cfg_vector, whatever address was latched. An acknowledge holds ready low for cfg_io_waits clocks.
- R9: ad_oe is low whenever rd_n and inta_n are both high, including throughout a write.
- R10: Ready is high after any clock edge at which rd_n, wr_n and inta_n were all sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe; shared lines hold the address while high |
| ad_i | input | 8 | Shared address/data lines, input side |
| addr_hi | input | 12 | Upper address bits |
| space_mem | input | 1 | 1 selects memory space, 0 selects I/O space |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| inta_n | input | 1 | Interrupt acknowledge strobe, active low |
| cfg_mem_waits | input | 3 | Wait clocks for memory-space cycles |
| cfg_io_waits | input | 3 | Wait clocks for I/O-space and acknowledge cycles |
| cfg_vector | input | 8 | Byte returned during acknowledge |
| ad_o | output | 8 | Shared lines, output side |
| ad_oe | output | 1 | Drive enable for ad_o; low releases the lines |
| ready | output | 1 | Low stretches the current cycle |

## Verification
The address test changes the shared lines after the address strobe falls. A design that kept following the bus would then read or write the wrong byte. Memory and I/O registers are loaded at the same low offset, so a design that ignored the space flag would return the other space's value. Writes just outside either range are followed by read-back of in-range storage, which exposes decoders that alias pages or commit misses. Wait counts of 0, 2, 3, 5 and 7 are timed clock by clock on reads, writes and acknowledges, so an off-by-one counter or a swapped space selection gives a visibly wrong count.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_MEM  = 2'd1,
    HIT_IO   = 2'd2
  } hit_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ack;
  } strobe_t;
endpackage

// File: rtl/bt_addr_latch.sv
module bt_addr_latch #(
  parameter int HI_W = 12,
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] ad_i,
  input  logic [HI_W-1:0] addr_hi,
  input  logic            space_mem,
  output logic [LO_W-1:0] lat_lo,
  output logic [HI_W-1:0] lat_hi,
  output logic            lat_mem
);
  // follow the bus while the strobe is high, hold once it drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_lo  <= '0;
      lat_hi  <= '0;
      lat_mem <= 1'b0;
    end else if (ale) begin
      lat_lo  <= ad_i;
      lat_hi  <= addr_hi;
      lat_mem <= space_mem;
    end
  end
endmodule

// File: rtl/bt_wait_gen.sv
module bt_wait_gen #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [WAIT_W-1:0] load_val,
  output logic              ready
);
  logic              active_q;
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active;
      if (!active)
        cnt_q <= '0;
      else if (!active_q)
        cnt_q <= load_val;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/bt_store.sv
module bt_store
  import bt_pkg::*;
#(
  parameter int LO_W  = 8,
  parameter int IO_AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  hit_e            hit,
  input  logic [LO_W-1:0] index,
  input  logic            wr_en,
  input  logic [LO_W-1:0] wdata,
  output logic [LO_W-1:0] rdata
);
  localparam int MEM_DEPTH = 1 << LO_W;
  localparam int IO_REGS   = 1 << IO_AW;

  logic [LO_W-1:0] mem_q [MEM_DEPTH];
  logic [IO_REGS-1:0][LO_W-1:0] io_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en && hit == HIT_MEM) begin
      mem_q[index] <= wdata;
    end
  end

  for (genvar gi = 0; gi < IO_REGS; gi++) begin : g_ioreg
    logic [LO_W-1:0] reg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reg_q <= '0;
      else if (wr_en && hit == HIT_IO && index[IO_AW-1:0] == IO_AW'(gi))
        reg_q <= wdata;
    end
    assign io_flat[gi] = reg_q;
  end

  always_comb begin
    case (hit)
      HIT_MEM: rdata = mem_q[index];
      HIT_IO:  rdata = io_flat[index[IO_AW-1:0]];
      default: rdata = '1;
    endcase
  end
endmodule

// File: rtl/bus_target.sv
module bus_target
  import bt_pkg::*;
#(
  parameter int              HI_W     = 12,
  parameter int              LO_W     = 8,
  parameter int              IO_AW    = 4,
  parameter int              WAIT_W   = 3,
  parameter logic [HI_W-1:0] MEM_PAGE = 12'h0A0,
  parameter logic [HI_W-1:0] IO_PAGE  = 12'h000,
  parameter logic [LO_W-1:0] IO_BASE  = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic              space_mem,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              inta_n,
  input  logic [WAIT_W-1:0] cfg_mem_waits,
  input  logic [WAIT_W-1:0] cfg_io_waits,
  input  logic [LO_W-1:0]   cfg_vector,
  output logic [LO_W-1:0]   ad_o,
  output logic              ad_oe,
  output logic              ready
);
  logic [LO_W-1:0]   lat_lo;
  logic [HI_W-1:0]   lat_hi;
  logic              lat_mem;
  hit_e              hit;
  strobe_t           st;
  logic              any_st;
  logic              wr_q;
  logic [LO_W-1:0]   wdat_q;
  logic              wr_commit;
  logic [WAIT_W-1:0] load_val;
  logic [LO_W-1:0]   rdata;

  bt_addr_latch #(.HI_W(HI_W), .LO_W(LO_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_i(ad_i), .addr_hi(addr_hi),
    .space_mem(space_mem), .lat_lo(lat_lo), .lat_hi(lat_hi), .lat_mem(lat_mem)
  );

  // space decode on the latched address
  always_comb begin
    hit = HIT_NONE;
    if (lat_mem && lat_hi == MEM_PAGE)
      hit = HIT_MEM;
    else if (!lat_mem && lat_hi == IO_PAGE &&
             lat_lo[LO_W-1:IO_AW] == IO_BASE[LO_W-1:IO_AW])
      hit = HIT_IO;
  end

  assign st.rd  = ~rd_n;
  assign st.wr  = ~wr_n;
  assign st.ack = ~inta_n;
  assign any_st = st.rd | st.wr | st.ack;

  // write data is taken while the strobe is low, committed on its release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wdat_q <= '0;
    end else begin
      wr_q <= st.wr;
      if (st.wr) wdat_q <= ad_i;
    end
  end

  assign wr_commit = wr_q & ~st.wr & (hit != HIT_NONE);

  bt_store #(.LO_W(LO_W), .IO_AW(IO_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .hit(hit), .index(lat_lo),
    .wr_en(wr_commit), .wdata(wdat_q), .rdata(rdata)
  );

  always_comb begin
    if (st.ack)
      load_val = cfg_io_waits;
    else if (hit == HIT_MEM)
      load_val = cfg_mem_waits;
    else if (hit == HIT_IO)
      load_val = cfg_io_waits;
    else
      load_val = '0;
  end

  bt_wait_gen #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(any_st), .load_val(load_val), .ready(ready)
  );

  // acknowledge wins over read; lines released otherwise
  assign ad_oe = st.rd | st.ack;
  always_comb begin
    if (st.ack)
      ad_o = cfg_vector;
    else if (st.rd)
      ad_o = rdata;
    else
      ad_o = '0;
  end
endmodule

// File: rtl/bus_target_chk.sv
module bus_target_chk #(
  parameter int LO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            inta_n,
  input logic [LO_W-1:0] cfg_vector,
  input logic [LO_W-1:0] ad_o,
  input logic            ad_oe,
  input logic            ready,
  input logic [LO_W-1:0] lat_lo
);
  // R9
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && inta_n) |-> !ad_oe);

  // R8
  ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> (ad_oe && ad_o == cfg_vector));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_n && wr_n && inta_n) |-> ready);

  // R2
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ale) |-> $stable(lat_lo));

  // R7
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(!(rd_n && wr_n && inta_n)));
endmodule

bind bus_target bus_target_chk #(.LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .inta_n(inta_n), .cfg_vector(cfg_vector), .ad_o(ad_o), .ad_oe(ad_oe),
  .ready(ready), .lat_lo(lat_lo)
);

// File: tb/bus_target_tb.sv
module bus_target_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  ad_i = 8'h00;
  logic [11:0] addr_hi = 12'h000;
  logic        space_mem = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        inta_n = 1'b1;
  logic [2:0]  cfg_mem_waits = 3'd0;
  logic [2:0]  cfg_io_waits = 3'd0;
  logic [7:0]  cfg_vector = 8'h00;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic        ready;

  int checks = 0;
  int errors = 0;

  bus_target dut_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_i(ad_i), .addr_hi(addr_hi),
    .space_mem(space_mem), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
    .cfg_mem_waits(cfg_mem_waits), .cfg_io_waits(cfg_io_waits),
    .cfg_vector(cfg_vector), .ad_o(ad_o), .ad_oe(ad_oe), .ready(ready)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // kind: 0 read, 1 write, 2 acknowledge
  task automatic bus_op(input int kind, input logic sp, input logic [11:0] hi,
                        input logic [7:0] lo, input logic [7:0] wd,
                        output logic [7:0] rdat, output int wcnt,
                        output logic oe_seen, output logic oe_after);
    @(negedge clk);
    if (kind != 2) begin
      ale = 1'b1; ad_i = lo; addr_hi = hi; space_mem = sp;
    end else begin
      ale = 1'b0; ad_i = 8'hEE; space_mem = 1'b0;
    end
    @(negedge clk);
    ale = 1'b0;
    addr_hi = 12'hFFF;
    ad_i = (kind == 1) ? wd : 8'hC3;
    if (kind == 0) rd_n = 1'b0;
    else if (kind == 1) wr_n = 1'b0;
    else inta_n = 1'b0;
    wcnt = 0;
    @(negedge clk);
    while (!ready && wcnt < 20) begin
      wcnt++;
      @(negedge clk);
    end
    rdat = ad_o;
    oe_seen = ad_oe;
    rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1;
    ad_i = 8'h00;
    @(negedge clk);
    oe_after = ad_oe;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; int w; logic o1, o2;
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(ad_oe == 1'b0, "R1 oe after reset", ad_oe, 0);
    bus_op(0, 1'b1, 12'h0A0, 8'h40, 8'h00, d, w, o1, o2);
    chk(d == 8'h00, "R1 memory cleared", d, 0);
    bus_op(0, 1'b0, 12'h000, 8'h35, 8'h00, d, w, o1, o2);
    chk(d == 8'h00, "R1 io register cleared", d, 0);
  endtask

  task automatic t_mem_rw();
    logic [7:0] d; int w; logic o1, o2;
    bus_op(1, 1'b1, 12'h0A0, 8'h40, 8'hA5, d, w, o1, o2);
    chk(o1 == 1'b0, "R9 released during write", o1, 0);
    chk(w == 0, "R7 zero waits on write", w, 0);
    bus_op(0, 1'b1, 12'h0A0, 8'h40, 8'h00, d, w, o1, o2);
    chk(d == 8'hA5, "R5 memory write committed", d, 8'hA5);
    chk(o1 == 1'b1, "R4 driven during read", o1, 1);
    chk(o2 == 1'b0, "R9 released after read", o2, 0);
  endtask

  task automatic t_latch();
    logic [7:0] d; int w; logic o1, o2;
    bus_op(1, 1'b1, 12'h0A0, 8'hC3, 8'h77, d, w, o1, o2);
    bus_op(1, 1'b1, 12'h0A0, 8'h12, 8'h5E, d, w, o1, o2);
    bus_op(0, 1'b1, 12'h0A0, 8'h12, 8'h00, d, w, o1, o2);
    chk(d == 8'h5E, "R2 address held after strobe falls", d, 8'h5E);
    bus_op(0, 1'b1, 12'h0A0, 8'hC3, 8'h00, d, w, o1, o2);
    chk(d == 8'h77, "R2 second address", d, 8'h77);
  endtask

  task automatic t_space();
    logic [7:0] d; int w; logic o1, o2;
    bus_op(1, 1'b0, 12'h000, 8'h35, 8'h3C, d, w, o1, o2);
    bus_op(1, 1'b1, 12'h0A0, 8'h35, 8'h11, d, w, o1, o2);
    bus_op(0, 1'b0, 12'h000, 8'h35, 8'h00, d, w, o1, o2);
    chk(d == 8'h3C, "R3 io register separate from memory", d, 8'h3C);
    bus_op(0, 1'b1, 12'h0A0, 8'h35, 8'h00, d, w, o1, o2);
    chk(d == 8'h11, "R3 memory byte separate from io", d, 8'h11);
  endtask

  task automatic t_waits();
    logic [7:0] d; int w; logic o1, o2;
    cfg_mem_waits = 3'd5; cfg_io_waits = 3'd2;
    bus_op(0, 1'b1, 12'h0A0, 8'h40, 8'h00, d, w, o1, o2);
    chk(w == 5, "R7 memory read waits", w, 5);
    chk(d == 8'hA5, "R4 data after waits", d, 8'hA5);
    bus_op(0, 1'b0, 12'h000, 8'h35, 8'h00, d, w, o1, o2);
    chk(w == 2, "R7 io read waits", w, 2);
    cfg_mem_waits = 3'd7;
    bus_op(1, 1'b1, 12'h0A0, 8'h41, 8'h99, d, w, o1, o2);
    chk(w == 7, "R7 memory write waits max", w, 7);
    chk(ready == 1'b1, "R10 ready high when idle", ready, 1);
  endtask

  task automatic t_miss();
    logic [7:0] d; int w; logic o1, o2;
    cfg_mem_waits = 3'd5; cfg_io_waits = 3'd2;
    bus_op(1, 1'b1, 12'h0A1, 8'h40, 8'hEE, d, w, o1, o2);
    chk(w == 0, "R6 no waits on missed write", w, 0);
    bus_op(1, 1'b0, 12'h000, 8'h45, 8'hEE, d, w, o1, o2);
    bus_op(0, 1'b1, 12'h0A0, 8'h40, 8'h00, d, w, o1, o2);
    chk(d == 8'hA5, "R6 missed write left memory", d, 8'hA5);
    bus_op(0, 1'b0, 12'h000, 8'h35, 8'h00, d, w, o1, o2);
    chk(d == 8'h3C, "R6 missed write left io", d, 8'h3C);
    bus_op(0, 1'b1, 12'h0A1, 8'h40, 8'h00, d, w, o1, o2);
    chk(d == 8'hFF, "R6 missed memory read", d, 8'hFF);
    chk(w == 0, "R6 ready stays high on miss", w, 0);
    bus_op(0, 1'b0, 12'h000, 8'h45, 8'h00, d, w, o1, o2);
    chk(d == 8'hFF, "R6 missed io read", d, 8'hFF);
  endtask

  task automatic t_ack();
    logic [7:0] d; int w; logic o1, o2;
    cfg_vector = 8'h4C; cfg_io_waits = 3'd3; cfg_mem_waits = 3'd6;
    bus_op(2, 1'b0, 12'h000, 8'h00, 8'h00, d, w, o1, o2);
    chk(d == 8'h4C, "R8 vector returned", d, 8'h4C);
    chk(o1 == 1'b1, "R8 driven during acknowledge", o1, 1);
    chk(w == 3, "R8 acknowledge waits", w, 3);
    chk(o2 == 1'b0, "R9 released after acknowledge", o2, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_rw();
    t_latch();
    t_space();
    t_waits();
    t_miss();
    t_ack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule